// File: doc/BRIEF.md
# Serial Command and Readback Port

This block is the slave end of a small synchronous serial link. While the host holds chip select low, the block collects 8-bit command words on the serial data input. Each bit is taken on a rising edge of the serial clock. When a word is complete, the block raises a one-cycle command strobe in the system clock domain. The strobe carries the full word and the word split into its 4-bit register address and 4-bit data nibble, so neighbouring blocks can act on register writes or on whole commands.

One command code (parameter `RD_CMD`, 8'h0F by default) asks for a readback. On that code the block takes a copy of its 16-bit holding input and sends it to the host most significant bit first, one bit on each falling serial clock edge. The host samples each bit on the rising edge that follows.

A mode input selects where the readback data goes. In 4-wire mode it leaves on a dedicated data output. In 3-wire mode the shared data line is turned around: the block drives it through a data/enable pad pair during the readback. All serial inputs pass through two synchroniser flops, and the serial clock edges are detected in the system clock domain.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, `cmd_stb_o`, `wr_stb_o`, `dout_o`, `sdio_o` and `sdio_oe_o` are all 0.
- R2: Command bits arrive least significant first. The first bit after chip select falls becomes bit 0 and the eighth becomes bit 7. `wr_addr_o` is word bits [3:0] and `wr_data_o` is word bits [7:4].
- R3: Each complete 8-bit command gives exactly one `cmd_stb_o` pulse, one system clock wide. During that pulse, `cmd_word_o` holds the received word.
- R4: `wr_stb_o` pulses together with `cmd_stb_o` for every command except `RD_CMD`. For `RD_CMD` it stays 0.
- R5: After `RD_CMD`, the value of `hold_i` at command completion is shifted out over the next 16 serial clock periods, bit 15 first. Each bit changes after a falling edge and is valid at the following rising edge.
- R6: In 4-wire mode (`mode_3w_i`=0), readback bits appear on `dout_o` and `sdio_oe_o` stays 0.
- R7: In 3-wire mode (`mode_3w_i`=1), readback bits appear on `sdio_o`. `sdio_oe_o` is 1 from the first readback falling edge until the 16th readback rising edge or until chip select rises, whichever comes first. `dout_o` stays 0.
- R8: Raising chip select discards a partly received command. The next frame starts again at bit 0.
- R9: Rising edges during a readback add no bits to a command. After the 16th readback bit, the next 8 bits in the same frame form a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_3w_i | input | 1 | 1 selects 3-wire readback, 0 selects 4-wire |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in (receive side of the shared pad) |
| sdio_o | output | 1 | Shared pad drive value during a 3-wire readback |
| sdio_oe_o | output | 1 | Shared pad output enable |
| dout_o | output | 1 | Dedicated readback output for 4-wire mode |
| hold_i | input | 16 | Holding register value offered for readback |
| cmd_stb_o | output | 1 | One-cycle strobe per complete command |
| cmd_word_o | output | 8 | Received command word |
| wr_stb_o | output | 1 | One-cycle write strobe for non-read commands |
| wr_addr_o | output | 4 | Register address field of the command |
| wr_data_o | output | 4 | Data nibble field of the command |

## Verification
The in-module assertions check the following on every cycle:
- a command strobe only follows the eighth accepted rising edge;
- an inactive chip select clears the bit count and the readback state;
- a readback ends only on its sixteenth rising edge or on a deselect;
- the readback data register changes only after a detected falling edge;
- the pad is driven only inside a readback.

Only the bench scenarios can show the rest: the bit order of commands and readback, the value of the copied holding register, the routing between `dout_o` and the shared pad for each mode, the discarding of a partial frame, and a new command following a readback in the same frame.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int HOLD_W = 16,
  parameter logic [ADDR_W+DATA_W-1:0] RD_CMD = 8'h0F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_3w_i,
  input  logic                     sclk_i,
  input  logic                     cs_n_i,
  input  logic                     sdio_i,
  output logic                     sdio_o,
  output logic                     sdio_oe_o,
  output logic                     dout_o,
  input  logic [HOLD_W-1:0]        hold_i,
  output logic                     cmd_stb_o,
  output logic [ADDR_W+DATA_W-1:0] cmd_word_o,
  output logic                     wr_stb_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o
);
  localparam int CMD_W = ADDR_W + DATA_W;
  localparam int BCW   = $clog2(CMD_W);
  localparam int RCW   = $clog2(HOLD_W);
  localparam logic [BCW-1:0] BC_LAST = BCW'(CMD_W - 1);
  localparam logic [RCW-1:0] RC_LAST = RCW'(HOLD_W - 1);

  logic [2:0]        sclk_s;
  logic [1:0]        cs_s;
  logic [1:0]        sdi_s;
  logic [CMD_W-1:0]  shreg;
  logic [BCW-1:0]    bit_cnt;
  logic [HOLD_W-1:0] rd_sh;
  logic [RCW-1:0]    rd_cnt;
  logic              rd_act, drv, dout_q, cmd_stb, wr_stb;

  wire rise   = sclk_s[1] & ~sclk_s[2];
  wire fall   = ~sclk_s[1] & sclk_s[2];
  wire cs_act = ~cs_s[1];
  wire sdi    = sdi_s[1];
  wire [CMD_W-1:0] next_word = {sdi, shreg[CMD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[0], cs_n_i};
      sdi_s  <= {sdi_s[0], sdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      rd_sh   <= '0;
      rd_cnt  <= '0;
      rd_act  <= 1'b0;
      drv     <= 1'b0;
      dout_q  <= 1'b0;
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        rd_act  <= 1'b0;
        drv     <= 1'b0;
      end else if (rd_act) begin
        if (fall) begin
          dout_q <= rd_sh[HOLD_W-1];
          rd_sh  <= {rd_sh[HOLD_W-2:0], 1'b0};
          drv    <= 1'b1;
        end
        if (rise) begin
          rd_cnt <= rd_cnt + 1'b1;
          if (rd_cnt == RC_LAST) begin
            rd_act <= 1'b0;
            drv    <= 1'b0;
          end
        end
      end else if (rise) begin
        shreg   <= next_word;
        bit_cnt <= (bit_cnt == BC_LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == BC_LAST) begin
          cmd_stb <= 1'b1;
          wr_stb  <= (next_word != RD_CMD);
          if (next_word == RD_CMD) begin
            rd_act <= 1'b1;
            rd_sh  <= hold_i;
            rd_cnt <= '0;
          end
        end
      end
    end
  end

  assign cmd_stb_o  = cmd_stb;
  assign wr_stb_o   = wr_stb;
  assign cmd_word_o = shreg;
  assign wr_addr_o  = shreg[ADDR_W-1:0];
  assign wr_data_o  = shreg[CMD_W-1:ADDR_W];
  assign sdio_oe_o  = drv & mode_3w_i;
  assign sdio_o     = drv & mode_3w_i & dout_q;
  assign dout_o     = drv & ~mode_3w_i & dout_q;

  assert_stb_after_last_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(rise && bit_cnt == BC_LAST && !rd_act && cs_act));

  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0 && !rd_act && !drv));

  assert_read_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_act) |-> $past(!cs_act || (rise && rd_cnt == RC_LAST)));

  assert_data_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> $past(fall));

  assert_drive_inside_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> rd_act);
endmodule

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb_top;
  localparam int H = 8;
  localparam int NV = 7;
  localparam logic [24:0] VEC [0:NV-1] = '{
    {1'b0, 8'h5A, 16'h0000},
    {1'b0, 8'h0F, 16'hA5C3},
    {1'b1, 8'h0F, 16'h8001},
    {1'b1, 8'hC3, 16'h0000},
    {1'b0, 8'h0F, 16'hFFFF},
    {1'b1, 8'h0F, 16'h1234},
    {1'b0, 8'h81, 16'h0000}
  };

  logic clk = 0, rst_n = 0, mode = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic [15:0] hold = 0;
  logic sdo, sdo_oe, dout, cstb, wstb;
  logic [7:0] cword;
  logic [3:0] waddr, wdata;
  int errors = 0, checks = 0, nstb = 0, nwr = 0, cyc = 0;
  logic [7:0] last_word;
  logic [3:0] last_addr, last_data;

  serial_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_3w_i(mode), .sclk_i(sclk), .cs_n_i(cs_n),
    .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(sdo_oe), .dout_o(dout), .hold_i(hold),
    .cmd_stb_o(cstb), .cmd_word_o(cword), .wr_stb_o(wstb), .wr_addr_o(waddr),
    .wr_data_o(wdata));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (cstb) begin nstb++; last_word = cword; last_addr = waddr; last_data = wdata; end
    if (wstb) nwr++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wait_clk(H); sclk = 1; wait_clk(H); sclk = 0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) send_bit(c[i]);
    wait_clk(6);
  endtask

  task automatic read_word(output logic [15:0] v, output bit oe_ok, output bit other_ok);
    oe_ok = 1; other_ok = 1; v = 0;
    for (int i = 0; i < 16; i++) begin
      wait_clk(H);
      v = {v[14:0], mode ? sdo : dout};
      if (sdo_oe !== mode) oe_ok = 0;
      if ((mode ? dout : sdo) !== 1'b0) other_ok = 0;
      sclk = 1; wait_clk(H); sclk = 0;
    end
    wait_clk(6);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    bit oe_ok, oth_ok;
    int s0, w0;
    wait_clk(4);
    // R1 reset state
    chk({cstb, wstb, dout, sdo, sdo_oe} == 5'b0, "R1 reset outputs", {cstb, wstb, dout, sdo, sdo_oe}, 0);
    rst_n = 1; wait_clk(4);
    chk({cstb, wstb, dout, sdo, sdo_oe} == 5'b0, "R1 after release", {cstb, wstb, dout, sdo, sdo_oe}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] c;
      c = VEC[v][23:16];
      mode = VEC[v][24]; hold = VEC[v][15:0];
      wait_clk(4); cs_n = 0; wait_clk(H);
      s0 = nstb; w0 = nwr;
      send_cmd(c);
      chk(nstb == s0 + 1, "R3 one strobe per command", nstb - s0, 1);
      chk(last_word == c, "R2 R3 command word", last_word, c);
      chk(last_addr == c[3:0] && last_data == c[7:4], "R2 address/data split", {last_data, last_addr}, c);
      chk(nwr == w0 + (c != 8'h0F), "R4 write strobe", nwr - w0, c != 8'h0F);
      if (c == 8'h0F) begin
        hold = ~hold;  // R5 later changes must not matter
        read_word(rv, oe_ok, oth_ok);
        chk(rv == VEC[v][15:0], "R5 readback MSB first", rv, VEC[v][15:0]);
        chk(oe_ok, mode ? "R7 pad enable during read" : "R6 pad enable stays low", oe_ok, 1);
        chk(oth_ok, mode ? "R7 dout_o idle" : "R6 shared pad idle", oth_ok, 1);
        chk(sdo_oe == 0, "R7 enable drops after 16 bits", sdo_oe, 0);
        s0 = nstb;
        send_cmd(8'h3C);  // R9 command after readback in same frame
        chk(nstb == s0 + 1 && last_word == 8'h3C, "R9 command after readback", last_word, 8'h3C);
      end
      cs_n = 1; wait_clk(8);
    end

    // R8 partial command discarded by deselect
    mode = 0; cs_n = 0; wait_clk(H);
    s0 = nstb;
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    cs_n = 1; wait_clk(8); cs_n = 0; wait_clk(H);
    send_cmd(8'h96);
    chk(nstb == s0 + 1 && last_word == 8'h96, "R8 partial frame discarded", last_word, 8'h96);
    cs_n = 1; wait_clk(8);

    // R7 readback aborted by deselect releases the pad
    mode = 1; hold = 16'hF0F0; cs_n = 0; wait_clk(H);
    send_cmd(8'h0F);
    for (int i = 0; i < 4; i++) begin
      wait_clk(H);
      chk(sdo_oe == 1 && sdo == hold[15 - i], "R7 partial 3-wire read", {sdo_oe, sdo}, {1'b1, hold[15 - i]});
      sclk = 1; wait_clk(H); sclk = 0;
    end
    wait_clk(H); cs_n = 1; wait_clk(6);
    chk(sdo_oe == 0, "R7 deselect releases pad", sdo_oe, 0);
    cs_n = 0; wait_clk(H);
    send_cmd(8'h21);
    chk(last_word == 8'h21, "R8 clean start after aborted read", last_word, 8'h21);
    cs_n = 1; wait_clk(8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule